// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache with Two Page Sizes

This block is a small, fully associative cache of address translations. Each lookup presents a 32-bit virtual address, the identifier of the address space that is running and the kind of access (load, store or instruction fetch). In the same cycle the block reports one of three outcomes: a permitted hit with the physical address, a protection fault, or a miss. Each cached entry records the address space that owns it. Translations from many address spaces can therefore stay resident at once, and a context switch does not have to empty the cache.

An entry maps either a 4 KB page or a 2 MB page. When both sizes cover the same address, the 4 KB entry is used. This lets a small window inside a large page carry its own permissions. An entry marked global matches every address space, which suits mappings shared by all processes. An external agent loads entries through a refill port. The cache can be emptied in a single cycle, or only the entries of one address space can be dropped.

Top module: `tlb_asid`

## Requirements
- R1: For a hit on a 4 KB entry, `lk_paddr` is the entry's 20-bit frame number followed by `lk_vaddr[11:0]` unchanged.
- R2: An entry matches only when it is valid, its page number equals `lk_vaddr[31:12]`, and either its identifier equals `lk_asid` or its global flag is set. An entry of another address space with the same page number does not produce a hit or a fault.
- R3: A 2 MB entry compares only page-number bits [19:9], which are address bits [31:21]. On a hit, `lk_paddr` is frame bits [19:9] followed by `lk_vaddr[20:0]`.
- R4: When a 4 KB entry and a 2 MB entry both match, the 4 KB entry alone decides the address and the permission outcome.
- R5: The access codes are 0 for read, 1 for write and 2 for execute. A matched entry whose read, write or execute bit for that code is clear gives `lk_fault`=1 and `lk_hit`=0. Code 3 always faults on a match.
- R6: A `flush_all` pulse leaves no entry valid from the next cycle on. A refill in the same cycle is discarded.
- R7: A `flush_asid_en` pulse invalidates every non-global entry whose identifier equals `flush_asid`. Global entries and entries of other address spaces stay valid.
- R8: A refill whose page number, identifier and size equal those of a valid entry overwrites that entry. Otherwise the refill takes the lowest-numbered invalid slot. When no slot is free, it takes the slot named by a round-robin pointer. The pointer starts at 0 after reset and advances by one only on such a replacement.
- R9: After reset no entry is valid and every lookup misses.
- R10: On a miss, `lk_hit`, `lk_fault` and `lk_paddr` are all zero. `lk_paddr` is also zero on a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_asid | input | 8 | Address-space identifier of the running context |
| lk_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| lk_hit | output | 1 | Translation found and access permitted |
| lk_fault | output | 1 | Translation found but access not permitted |
| lk_paddr | output | 32 | Physical address, zero unless hit |
| fill_en | input | 1 | Write one entry this cycle |
| fill_vpn | input | 20 | Page number of the new entry |
| fill_pfn | input | 20 | Frame number of the new entry |
| fill_asid | input | 8 | Owner identifier of the new entry |
| fill_huge | input | 1 | New entry maps a 2 MB page |
| fill_glob | input | 1 | New entry matches any identifier |
| fill_r | input | 1 | Read allowed |
| fill_w | input | 1 | Write allowed |
| fill_x | input | 1 | Execute allowed |
| flush_all | input | 1 | Invalidate all entries |
| flush_asid_en | input | 1 | Invalidate the entries of one identifier |
| flush_asid | input | 8 | Identifier to invalidate |

## Verification
A corrupted tag or identifier shows up on the first lookup of that page as a miss where a hit was expected, or as a hit delivered to the wrong address space. A wrong size flag or a wrong priority choice changes the upper bits of `lk_paddr` in the same cycle. A flush or refill that goes astray becomes visible one cycle after the command, on the next lookup of an affected page. A round-robin pointer that drifts is only seen when the cache is full. For that reason the bench fills every slot and then tracks which old page disappears after each extra refill.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  localparam int VA_W       = 32;
  localparam int OFF_W      = 12;
  localparam int HUGE_OFF_W = 21;
  localparam int VPN_W      = VA_W - OFF_W;
  localparam int PFN_W      = 20;
  localparam int ASID_W     = 8;
  localparam int HP_LO      = HUGE_OFF_W - OFF_W;

  typedef enum logic [1:0] {
    ACC_RD = 2'd0,
    ACC_WR = 2'd1,
    ACC_EX = 2'd2,
    ACC_NA = 2'd3
  } acc_e;

  typedef struct packed {
    logic              vld;
    logic              glb;
    logic              huge;
    logic              pr;
    logic              pw;
    logic              px;
    logic [ASID_W-1:0] asid;
    logic [VPN_W-1:0]  vpn;
    logic [PFN_W-1:0]  pfn;
  } tlb_ent_t;

  // page-number comparison at the entry's granularity
  function automatic logic vpn_eq(input logic huge,
                                  input logic [VPN_W-1:0] a,
                                  input logic [VPN_W-1:0] b);
    if (huge) return a[VPN_W-1:HP_LO] == b[VPN_W-1:HP_LO];
    return a == b;
  endfunction

  function automatic logic tag_hit(input tlb_ent_t e,
                                   input logic [VPN_W-1:0] vpn,
                                   input logic [ASID_W-1:0] asid);
    return e.vld && vpn_eq(e.huge, e.vpn, vpn) && (e.glb || (e.asid == asid));
  endfunction

  function automatic logic same_key(input tlb_ent_t e,
                                    input logic [VPN_W-1:0] vpn,
                                    input logic [ASID_W-1:0] asid,
                                    input logic huge);
    return e.vld && (e.huge == huge) && (e.asid == asid) && vpn_eq(huge, e.vpn, vpn);
  endfunction

  function automatic logic [VA_W-1:0] xlate(input tlb_ent_t e,
                                            input logic [VA_W-1:0] va);
    if (e.huge) return {e.pfn[PFN_W-1:HP_LO], va[HUGE_OFF_W-1:0]};
    return {e.pfn, va[OFF_W-1:0]};
  endfunction

  function automatic logic perm_ok(input tlb_ent_t e, input logic [1:0] acc);
    case (acc)
      ACC_RD:  return e.pr;
      ACC_WR:  return e.pw;
      ACC_EX:  return e.px;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/tlb_match.sv
module tlb_match
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8
) (
  input  tlb_ent_t [ENTRIES-1:0] ents,
  input  logic [VPN_W-1:0]       vpn,
  input  logic [ASID_W-1:0]      asid,
  output logic [ENTRIES-1:0]     small_vec,
  output logic [ENTRIES-1:0]     huge_vec
);

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    logic m;
    assign m            = tag_hit(ents[i], vpn, asid);
    assign small_vec[i] = m && !ents[i].huge;
    assign huge_vec[i]  = m &&  ents[i].huge;
  end

endmodule

// File: rtl/tlb_pick.sv
module tlb_pick #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0] small_vec,
  input  logic [ENTRIES-1:0] huge_vec,
  output logic               any,
  output logic               is_huge,
  output logic [IDX_W-1:0]   idx
);

  logic [IDX_W-1:0] s_idx, h_idx;

  always_comb begin
    s_idx = '0;
    h_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (small_vec[i]) s_idx = IDX_W'(i);
      if (huge_vec[i])  h_idx = IDX_W'(i);
    end
  end

  // a 4 KB match takes precedence over any 2 MB match
  assign any     = (|small_vec) || (|huge_vec);
  assign is_huge = !(|small_vec) && (|huge_vec);
  assign idx     = (|small_vec) ? s_idx : h_idx;

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  tlb_ent_t [ENTRIES-1:0] ents,
  input  logic                   fill_en,
  input  logic                   flush_all,
  input  logic [VPN_W-1:0]       fill_vpn,
  input  logic [ASID_W-1:0]      fill_asid,
  input  logic                   fill_huge,
  output logic [IDX_W-1:0]       slot,
  output logic [IDX_W-1:0]       rr_ptr,
  output logic                   rr_adv
);

  logic [ENTRIES-1:0] dup_vec, free_vec;
  logic [IDX_W-1:0]   dup_idx, free_idx;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_scan
    assign dup_vec[i]  = same_key(ents[i], fill_vpn, fill_asid, fill_huge);
    assign free_vec[i] = !ents[i].vld;
  end

  always_comb begin
    dup_idx  = '0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (dup_vec[i])  dup_idx  = IDX_W'(i);
      if (free_vec[i]) free_idx = IDX_W'(i);
    end
  end

  always_comb begin
    if (|dup_vec)       slot = dup_idx;
    else if (|free_vec) slot = free_idx;
    else                slot = rr_ptr;
  end

  assign rr_adv = fill_en && !flush_all && !(|dup_vec) && !(|free_vec);

  always_ff @(posedge clk) begin
    if (!rst_n)
      rr_ptr <= '0;
    else if (rr_adv)
      rr_ptr <= (rr_ptr == IDX_W'(ENTRIES - 1)) ? '0 : rr_ptr + 1'b1;
  end

endmodule

// File: rtl/tlb_asid.sv
module tlb_asid
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VA_W-1:0]   lk_vaddr,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [1:0]        lk_acc,
  output logic              lk_hit,
  output logic              lk_fault,
  output logic [VA_W-1:0]   lk_paddr,
  input  logic              fill_en,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic              fill_huge,
  input  logic              fill_glob,
  input  logic              fill_r,
  input  logic              fill_w,
  input  logic              fill_x,
  input  logic              flush_all,
  input  logic              flush_asid_en,
  input  logic [ASID_W-1:0] flush_asid
);

  tlb_ent_t [ENTRIES-1:0] ents;
  logic [ENTRIES-1:0]     valid_vec;
  logic [ENTRIES-1:0]     small_vec, huge_vec;
  logic                   sel_any, sel_huge;
  logic [IDX_W-1:0]       sel_idx;
  logic [IDX_W-1:0]       fill_slot, rr_ptr;
  logic                   rr_adv;
  logic                   perm_pass;
  tlb_ent_t               sel_ent, new_ent;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_vld
    assign valid_vec[i] = ents[i].vld;
  end

  tlb_match #(.ENTRIES(ENTRIES)) u_match (
    .ents      (ents),
    .vpn       (lk_vaddr[VA_W-1:OFF_W]),
    .asid      (lk_asid),
    .small_vec (small_vec),
    .huge_vec  (huge_vec)
  );

  tlb_pick #(.ENTRIES(ENTRIES)) u_pick (
    .small_vec (small_vec),
    .huge_vec  (huge_vec),
    .any       (sel_any),
    .is_huge   (sel_huge),
    .idx       (sel_idx)
  );

  tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk       (clk),
    .rst_n     (rst_n),
    .ents      (ents),
    .fill_en   (fill_en),
    .flush_all (flush_all),
    .fill_vpn  (fill_vpn),
    .fill_asid (fill_asid),
    .fill_huge (fill_huge),
    .slot      (fill_slot),
    .rr_ptr    (rr_ptr),
    .rr_adv    (rr_adv)
  );

  assign sel_ent   = ents[sel_idx];
  assign perm_pass = perm_ok(sel_ent, lk_acc);
  assign lk_hit    = sel_any && perm_pass;
  assign lk_fault  = sel_any && !perm_pass;
  assign lk_paddr  = lk_hit ? xlate(sel_ent, lk_vaddr) : '0;

  always_comb begin
    new_ent      = '0;
    new_ent.vld  = 1'b1;
    new_ent.glb  = fill_glob;
    new_ent.huge = fill_huge;
    new_ent.pr   = fill_r;
    new_ent.pw   = fill_w;
    new_ent.px   = fill_x;
    new_ent.asid = fill_asid;
    new_ent.vpn  = fill_vpn;
    new_ent.pfn  = fill_pfn;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ents <= '0;
    end else if (flush_all) begin
      for (int i = 0; i < ENTRIES; i++) ents[i].vld <= 1'b0;
    end else begin
      for (int i = 0; i < ENTRIES; i++)
        if (flush_asid_en && !ents[i].glb && ents[i].asid == flush_asid)
          ents[i].vld <= 1'b0;
      if (fill_en) ents[fill_slot] <= new_ent;
    end
  end

endmodule

// File: rtl/tlb_asid_chk.sv
module tlb_asid_chk
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic [VA_W-1:0]    lk_vaddr,
  input logic               lk_hit,
  input logic               lk_fault,
  input logic [VA_W-1:0]    lk_paddr,
  input logic               fill_en,
  input logic               flush_all,
  input logic               flush_asid_en,
  input logic [ENTRIES-1:0] valid_vec,
  input logic [ENTRIES-1:0] small_vec,
  input logic [ENTRIES-1:0] huge_vec,
  input logic               sel_huge,
  input logic [IDX_W-1:0]   fill_slot,
  input logic [IDX_W-1:0]   rr_ptr,
  input logic               rr_adv
);

  p_hit_fault_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_hit && lk_fault));

  p_small_offset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && !sel_huge) |-> lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]);

  p_huge_offset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && sel_huge) |-> lk_paddr[HUGE_OFF_W-1:0] == lk_vaddr[HUGE_OFF_W-1:0]);

  p_small_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((|small_vec) && (|huge_vec)) |-> !sel_huge);

  p_flush_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (valid_vec == '0));

  p_keep_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush_all && !flush_asid_en) |=> ($countones(valid_vec) >= $past($countones(valid_vec))));

  p_fill_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !flush_all) |=> valid_vec[$past(fill_slot)]);

  p_rr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rr_adv |=> $stable(rr_ptr));

  p_miss_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|small_vec) && !(|huge_vec)) |-> (!lk_hit && !lk_fault && lk_paddr == '0));

endmodule

bind tlb_asid tlb_asid_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .lk_vaddr      (lk_vaddr),
  .lk_hit        (lk_hit),
  .lk_fault      (lk_fault),
  .lk_paddr      (lk_paddr),
  .fill_en       (fill_en),
  .flush_all     (flush_all),
  .flush_asid_en (flush_asid_en),
  .valid_vec     (valid_vec),
  .small_vec     (small_vec),
  .huge_vec      (huge_vec),
  .sel_huge      (sel_huge),
  .fill_slot     (fill_slot),
  .rr_ptr        (rr_ptr),
  .rr_adv        (rr_adv)
);

// File: tb/tlb_asid_tb.sv
`timescale 1ns/1ps
module tlb_asid_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic [7:0]  lk_asid = '0;
  logic [1:0]  lk_acc = '0;
  logic        lk_hit, lk_fault;
  logic [31:0] lk_paddr;
  logic        fill_en = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [19:0] fill_pfn = '0;
  logic [7:0]  fill_asid = '0;
  logic        fill_huge = 1'b0, fill_glob = 1'b0;
  logic        fill_r = 1'b0, fill_w = 1'b0, fill_x = 1'b0;
  logic        flush_all = 1'b0, flush_asid_en = 1'b0;
  logic [7:0]  flush_asid = '0;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  tlb_asid u_dut (.*);

  // {vaddr[75:44], asid[43:36], acc[35:34], hit[33], fault[32], paddr[31:0]}
  localparam int NV = 13;
  localparam logic [75:0] VEC [NV] = '{
    {32'h00010ABC, 8'd1, 2'd0, 1'b1, 1'b0, 32'hAAAAAABC},
    {32'h00010ABC, 8'd2, 2'd0, 1'b1, 1'b0, 32'hBBBBBABC},
    {32'h00010ABC, 8'd3, 2'd0, 1'b0, 1'b0, 32'h00000000},
    {32'h00010ABC, 8'd1, 2'd1, 1'b1, 1'b0, 32'hAAAAAABC},
    {32'h00010ABC, 8'd1, 2'd2, 1'b0, 1'b1, 32'h00000000},
    {32'h00010ABC, 8'd2, 2'd1, 1'b0, 1'b1, 32'h00000000},
    {32'h002FF123, 8'd1, 2'd2, 1'b1, 1'b0, 32'h124FF123},
    {32'h00234456, 8'd1, 2'd0, 1'b1, 1'b0, 32'h55555456},
    {32'h00234456, 8'd1, 2'd1, 1'b0, 1'b1, 32'h00000000},
    {32'h00234456, 8'd2, 2'd0, 1'b0, 1'b0, 32'h00000000},
    {32'h80000010, 8'd7, 2'd2, 1'b1, 1'b0, 32'h00001010},
    {32'h80000010, 8'd7, 2'd1, 1'b0, 1'b1, 32'h00000000},
    {32'h00400000, 8'd1, 2'd3, 1'b0, 1'b0, 32'h00000000}
  };

  function automatic string vtag(input int i);
    case (i)
      0, 1, 3: return "R1";
      2, 9:    return "R2";
      4, 5, 11: return "R5";
      6, 12:   return "R3";
      7, 8:    return "R4";
      default: return "R2";
    endcase
  endfunction

  task automatic check(input string tag, input logic [33:0] act, input logic [33:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got hit=%0b fault=%0b pa=%h, expected hit=%0b fault=%0b pa=%h",
               tag, act[33], act[32], act[31:0], exp[33], exp[32], exp[31:0]);
    end
  endtask

  task automatic look(input logic [31:0] va, input logic [7:0] asid, input logic [1:0] acc,
                      input logic eh, input logic ef, input logic [31:0] epa, input string tag);
    @(negedge clk);
    lk_vaddr = va; lk_asid = asid; lk_acc = acc;
    #1;
    check(tag, {lk_hit, lk_fault, lk_paddr}, {eh, ef, epa});
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [19:0] pfn, input logic [7:0] asid,
                      input logic huge, input logic glb, input logic [2:0] rwx);
    @(negedge clk);
    fill_en = 1'b1; fill_vpn = vpn; fill_pfn = pfn; fill_asid = asid;
    fill_huge = huge; fill_glob = glb; {fill_r, fill_w, fill_x} = rwx;
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9: empty after reset
    look(32'h00010ABC, 8'd1, 2'd0, 1'b0, 1'b0, 32'h0, "R9");
    look(32'h80000010, 8'd0, 2'd0, 1'b0, 1'b0, 32'h0, "R9");

    fill(20'h00010, 20'hAAAAA, 8'd1, 1'b0, 1'b0, 3'b110);
    fill(20'h00010, 20'hBBBBB, 8'd2, 1'b0, 1'b0, 3'b101);
    fill(20'h00200, 20'h12400, 8'd1, 1'b1, 1'b0, 3'b111);
    fill(20'h00234, 20'h55555, 8'd1, 1'b0, 1'b0, 3'b100);
    fill(20'h80000, 20'h00001, 8'd0, 1'b0, 1'b1, 3'b101);

    for (int i = 0; i < NV; i++)
      look(VEC[i][75:44], VEC[i][43:36], VEC[i][35:34],
           VEC[i][33], VEC[i][32], VEC[i][31:0], vtag(i));

    // R10: miss must not leak an address
    look(32'h7FFFF000, 8'd1, 2'd0, 1'b0, 1'b0, 32'h0, "R10");

    // R8: same key rewrites in place with new frame and permissions
    fill(20'h00010, 20'hCCCCC, 8'd2, 1'b0, 1'b0, 3'b110);
    look(32'h00010ABC, 8'd2, 2'd1, 1'b1, 1'b0, 32'hCCCCCABC, "R8");

    // R7: drop identifier 1 only; global and identifier 2 stay
    @(negedge clk);
    flush_asid_en = 1'b1; flush_asid = 8'd1;
    @(negedge clk);
    flush_asid_en = 1'b0;
    look(32'h00010ABC, 8'd1, 2'd0, 1'b0, 1'b0, 32'h0, "R7");
    look(32'h002FF123, 8'd1, 2'd0, 1'b0, 1'b0, 32'h0, "R7");
    look(32'h00010ABC, 8'd2, 2'd0, 1'b1, 1'b0, 32'hCCCCCABC, "R7");
    look(32'h80000010, 8'd1, 2'd0, 1'b1, 1'b0, 32'h00001010, "R7");

    // R6: flush everything, a same-cycle refill is discarded
    @(negedge clk);
    flush_all = 1'b1;
    fill_en = 1'b1; fill_vpn = 20'h00777; fill_pfn = 20'h00777; fill_asid = 8'd4;
    fill_huge = 1'b0; fill_glob = 1'b0; {fill_r, fill_w, fill_x} = 3'b100;
    @(negedge clk);
    flush_all = 1'b0; fill_en = 1'b0;
    look(32'h80000010, 8'd0, 2'd0, 1'b0, 1'b0, 32'h0, "R6");
    look(32'h00777000, 8'd4, 2'd0, 1'b0, 1'b0, 32'h0, "R6");
    look(32'h00010ABC, 8'd2, 2'd0, 1'b0, 1'b0, 32'h0, "R6");

    // R8: fill all slots, then round-robin replacement from slot 0
    for (int i = 0; i < 8; i++)
      fill(20'h00100 + 20'(i), 20'h00F00 + 20'(i), 8'd5, 1'b0, 1'b0, 3'b100);
    look(32'h00107004, 8'd5, 2'd0, 1'b1, 1'b0, 32'h00F07004, "R8");
    fill(20'h00200, 20'h00E00, 8'd5, 1'b0, 1'b0, 3'b100);
    look(32'h00100000, 8'd5, 2'd0, 1'b0, 1'b0, 32'h0, "R8");
    look(32'h00200000, 8'd5, 2'd0, 1'b1, 1'b0, 32'h00E00000, "R8");
    look(32'h00101000, 8'd5, 2'd0, 1'b1, 1'b0, 32'h00F01000, "R8");
    fill(20'h00201, 20'h00E01, 8'd5, 1'b0, 1'b0, 3'b100);
    look(32'h00101000, 8'd5, 2'd0, 1'b0, 1'b0, 32'h0, "R8");
    look(32'h00102000, 8'd5, 2'd0, 1'b1, 1'b0, 32'h00F02000, "R8");
    look(32'h00200000, 8'd5, 2'd0, 1'b1, 1'b0, 32'h00E00000, "R8");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule